// File: doc/BRIEF.md
# Host Port Ready Handshake Controller

This block is the slave side of a host port. An external host with a 16-bit data path uses it to reach a 32-bit internal memory bus. The host sees three registers: control, address and data. It reaches each of them as two half-word accesses. The host qualifies an access with a chip-select and two data strobes. The block merges these into one internal strobe. An access runs while that strobe is low.

Data accesses come in two forms. The auto-increment form goes through an 8-word write FIFO and an 8-word read FIFO. The fixed-address form makes one single-word memory transfer per access. A prefetch command fills the read FIFO from the current address. An active-low ready output stalls the host only in certain cases. Those cases depend on the access type, the half-word position, the auto-increment mode and the FIFO occupancy. The memory side is a request/acknowledge port. A request holds its address, data and direction until it is acknowledged.

Top module: `hostport_ready_ctrl`

## Requirements
- R1: The internal strobe is low only when `host_sel_n` is 0 and exactly one of `strb_a_n` and `strb_b_n` is 0. With both data strobes low, or with `host_sel_n` high, no register changes.
- R2: While `host_sel_n` is 1, `host_ready_n` is 0, even if an access was stalled when chip-select rose.
- R3: A write to the address register (`reg_sel`=10) stalls in three cases, on either half: while the write FIFO holds words, while a prefetch fill is running, or within 3 cycles after the previous address-register half completed. Otherwise it completes without a stall.
- R4: A write to a data register stalls while the write FIFO is full (8 words) or is being flushed. When the FIFO becomes full, it is flushed completely to memory. Below that level, auto-increment data writes never stall.
- R5: An auto-increment data read (`reg_sel`=01) stalls only on the first half, and only while the read FIFO is empty. Words are returned in ascending address order.
- R6: A fixed-address data read (`reg_sel`=11) always stalls on its first half until a fresh single-word fetch from the current address returns. Its second half never stalls.
- R7: Reads of the control and address registers never stall. The address register returns bits 15:0 on the first half and bits 31:16 on the second half.
- R8: A fixed-address data write completes its first half without a stall. Its second half stalls until the whole word has been written to memory.
- R9: A completed auto-increment word (second half, read or write) advances the address register by 4. Fixed-address accesses leave it unchanged.
- R10: An address-register write first drains the write FIFO to memory in push order. When its second half completes, the read FIFO is emptied and later fills start at the new address.
- R11: Writing 1 to bit 0 of the control register's first half, while no fill is running, empties the read FIFO and starts filling it from the current address. A first-half control read returns the fill-active flag in bit 0 and the flush flag in bit 1, with all other bits 0.
- R12: Every data word is split so that the first half (`half_sel`=0) carries bits 15:0 and the second half (`half_sel`=1) carries bits 31:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel_n | input | 1 | Host chip-select, active low |
| strb_a_n | input | 1 | Host data strobe A |
| strb_b_n | input | 1 | Host data strobe B |
| host_rd | input | 1 | 1 = read, 0 = write |
| reg_sel | input | 2 | 00 control, 01 auto-increment data, 10 address, 11 fixed data |
| half_sel | input | 1 | 0 first half-word, 1 second half-word |
| hd_in | input | 16 | Host write data |
| hd_out | output | 16 | Host read data |
| host_ready_n | output | 1 | Ready, active low (1 = stall) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |

## Verification
The full-FIFO stall is the hardest case to reach from the ports. Auto-increment writes never drain by themselves, so the bench first pushes eight words with no stall. The ninth word must then stall until the forced flush empties the FIFO. The stimulus also times address writes tightly, so that one lands during the settle window of the previous write and another lands during a running prefetch. It then reads the stored words back through fixed-address reads to confirm that the flush kept their order.

// File: rtl/hostport_ready_ctrl.sv
module hostport_ready_ctrl #(
  parameter int WDEPTH = 8,
  parameter int RDEPTH = 8,
  parameter int SETTLE = 3,
  parameter int AW     = 32,
  parameter int HW     = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_sel_n,
  input  logic          strb_a_n,
  input  logic          strb_b_n,
  input  logic          host_rd,
  input  logic [1:0]    reg_sel,
  input  logic          half_sel,
  input  logic [15:0]   hd_in,
  output logic [15:0]   hd_out,
  output logic          host_ready_n,
  output logic          mem_req,
  output logic          mem_we,
  output logic [31:0]   mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack
);
  localparam int DW  = 2 * HW;
  localparam int WPW = $clog2(WDEPTH);
  localparam int RPW = $clog2(RDEPTH);
  localparam int SW  = $clog2(SETTLE + 1);

  typedef enum logic [2:0] {E_IDLE, E_DRAIN, E_FILL, E_SWR, E_SRD} eng_t;
  eng_t st;

  logic [AW-1:0]  addr, fill_addr;
  logic [HW-1:0]  lo_hold;
  logic [DW-1:0]  rd_word;
  logic [AW-1:0]  wq_a [WDEPTH];
  logic [DW-1:0]  wq_d [WDEPTH];
  logic [DW-1:0]  rq   [RDEPTH];
  logic [WPW-1:0] wwp, wrp;
  logic [RPW-1:0] rwp, rrp;
  logic [WPW:0]   wcount, wcount_nx;
  logic [RPW:0]   rcount, rcount_nx;
  logic [SW-1:0]  settle;
  logic done, flush, fill_on, sw_done, sr_done;

  wire stb_low = ~host_sel_n & (strb_a_n ^ strb_b_n);
  wire wr      = ~host_rd;
  wire is_ctl  = reg_sel == 2'b00;
  wire is_ai   = reg_sel == 2'b01;
  wire is_adr  = reg_sel == 2'b10;
  wire is_fx   = reg_sel == 2'b11;
  wire live    = stb_low & ~done;
  wire wfull   = wcount == (WPW+1)'(WDEPTH);
  wire wempty  = wcount == '0;
  wire rempty  = rcount == '0;

  logic blocked;
  always_comb begin
    blocked = 1'b0;
    if (wr) begin
      if (is_adr)     blocked = ~wempty | fill_on | (settle != '0);
      else if (is_ai) blocked = wfull | flush;
      else if (is_fx) blocked = half_sel ? ~sw_done : (wfull | flush);
    end else begin
      if (is_ai)      blocked = ~half_sel & rempty;
      else if (is_fx) blocked = ~half_sel & ~sr_done;
    end
  end

  wire act     = live & ~blocked;
  assign host_ready_n = live & blocked;

  wire sw_want  = live & wr & is_fx & half_sel & ~sw_done;
  wire sr_want  = live & host_rd & is_fx & ~half_sel & ~sr_done;
  wire flush_tr = wfull | (live & ~wempty & ((wr & is_adr) | is_fx));
  wire prefetch = act & wr & is_ctl & ~half_sel & hd_in[0] & ~fill_on;
  wire miss     = live & host_rd & is_ai & ~half_sel & rempty & ~fill_on;
  wire adr_hi   = act & wr & is_adr & half_sel;
  wire w_push   = act & wr & is_ai & half_sel;
  wire w_pop    = (st == E_DRAIN) & mem_ack;
  wire r_push   = (st == E_FILL) & mem_ack;
  wire r_pop    = act & host_rd & is_ai & ~half_sel;
  wire ai_word  = act & is_ai & half_sel;

  assign wcount_nx = wcount + (WPW+1)'(w_push) - (WPW+1)'(w_pop);
  assign rcount_nx = (prefetch | adr_hi) ? '0 : rcount + (RPW+1)'(r_push) - (RPW+1)'(r_pop);
  assign mem_req   = st != E_IDLE;
  assign mem_we    = (st == E_DRAIN) | (st == E_SWR);

  always_comb begin
    hd_out = '0;
    case (reg_sel)
      2'b00: hd_out = half_sel ? 16'h0 : {14'h0, flush, fill_on};
      2'b10: hd_out = half_sel ? addr[31:16] : addr[15:0];
      2'b01: hd_out = half_sel ? rd_word[31:16] : (done ? rd_word[15:0] : rq[rrp][15:0]);
      default: hd_out = half_sel ? rd_word[31:16] : rd_word[15:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (w_push) begin
      wq_a[wwp] <= addr;
      wq_d[wwp] <= {hd_in, lo_hold};
    end
    if (r_push) rq[rwp] <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= E_IDLE; addr <= '0; fill_addr <= '0; lo_hold <= '0; rd_word <= '0;
      wwp <= '0; wrp <= '0; rwp <= '0; rrp <= '0; wcount <= '0; rcount <= '0;
      settle <= '0; done <= 1'b0; flush <= 1'b0; fill_on <= 1'b0;
      sw_done <= 1'b0; sr_done <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
    end else begin
      done   <= stb_low & (done | act);
      wcount <= wcount_nx;
      rcount <= rcount_nx;
      flush  <= (flush | flush_tr) & (wcount_nx != '0);
      if (act & wr & is_adr)  settle <= SW'(SETTLE);
      else if (settle != '0)  settle <= settle - 1'b1;

      if (prefetch | miss)                              fill_on <= 1'b1;
      else if (r_push && rcount_nx == (RPW+1)'(RDEPTH)) fill_on <= 1'b0;

      if (act & wr & ~half_sel & (is_ai | is_fx)) lo_hold <= hd_in;
      if (act & wr & is_adr & ~half_sel)          addr[15:0] <= hd_in;
      if (adr_hi) begin
        addr[31:16] <= hd_in;
        fill_addr   <= {hd_in, addr[15:0]};
      end
      if (prefetch) fill_addr <= addr;
      if (prefetch | adr_hi) begin rwp <= '0; rrp <= '0; end
      if (ai_word) addr <= addr + AW'(4);
      if (w_push)  wwp  <= wwp + 1'b1;
      if (r_pop) begin
        rd_word <= rq[rrp];
        rrp     <= rrp + 1'b1;
      end
      if (act & wr & is_fx & half_sel)       sw_done <= 1'b0;
      if (act & host_rd & is_fx & ~half_sel) sr_done <= 1'b0;

      case (st)
        E_IDLE:
          if (flush & ~wempty) begin
            st <= E_DRAIN; mem_addr <= wq_a[wrp]; mem_wdata <= wq_d[wrp];
          end else if (sw_want & wempty) begin
            st <= E_SWR; mem_addr <= addr; mem_wdata <= {hd_in, lo_hold};
          end else if (sr_want & wempty) begin
            st <= E_SRD; mem_addr <= addr;
          end else if (fill_on && rcount < (RPW+1)'(RDEPTH)) begin
            st <= E_FILL; mem_addr <= fill_addr;
          end
        E_DRAIN: if (mem_ack) begin st <= E_IDLE; wrp <= wrp + 1'b1; end
        E_FILL:  if (mem_ack) begin
                   st <= E_IDLE; rwp <= rwp + 1'b1; fill_addr <= fill_addr + AW'(4);
                 end
        E_SWR:   if (mem_ack) begin st <= E_IDLE; sw_done <= 1'b1; end
        E_SRD:   if (mem_ack) begin st <= E_IDLE; sr_done <= 1'b1; rd_word <= mem_rdata; end
        default: st <= E_IDLE;
      endcase
    end
  end

  assert_deselect_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    host_sel_n |-> !host_ready_n);
  assert_wfifo_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wcount <= (WPW+1)'(WDEPTH));
  assert_rfifo_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rcount <= (RPW+1)'(RDEPTH));
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  assert_single_write_after_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == E_SWR) |-> wempty);
  assert_fill_room_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == E_FILL) |-> rcount < (RPW+1)'(RDEPTH));
endmodule

// File: tb/test_hostport_ready_ctrl.sv
`timescale 1ns/1ps
module test_hostport_ready_ctrl;
  logic clk = 0, rst_n = 0;
  logic host_sel_n = 1, strb_a_n = 1, strb_b_n = 1, host_rd = 1, half_sel = 0;
  logic [1:0] reg_sel = 0;
  logic [15:0] hd_in = 0, hd_out;
  logic host_ready_n, mem_req, mem_we, mem_ack = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [31:0] mem [64];
  int cnt = 0, checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  hostport_ready_ctrl i_hostport_ready_ctrl (.*);

  assign mem_rdata = mem[mem_addr[7:2]];
  always @(posedge clk) begin
    if (mem_ack) begin mem_ack <= 0; cnt <= 0; end
    else if (mem_req) begin
      if (cnt == 1) begin
        mem_ack <= 1;
        if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
      end
      cnt <= cnt + 1;
    end
  end

  typedef struct packed {
    logic [7:0] gap; logic rd; logic [1:0] sel; logic half; logic [15:0] wd;
    logic ew; logic cd; logic [15:0] ed; logic [3:0] req;
  } vec_t;

  localparam vec_t VT [32] = '{
    '{8'd0,  1'b1,2'd0,1'b0,16'h0000,1'b0,1'b1,16'h0000,4'd11}, // R11 idle status
    '{8'd0,  1'b0,2'd2,1'b0,16'h0010,1'b0,1'b0,16'h0000,4'd3},  // R3
    '{8'd0,  1'b0,2'd2,1'b1,16'h0000,1'b1,1'b0,16'h0000,4'd3},  // R3 back-to-back
    '{8'd0,  1'b1,2'd2,1'b0,16'h0000,1'b0,1'b1,16'h0010,4'd7},  // R7
    '{8'd0,  1'b1,2'd2,1'b1,16'h0000,1'b0,1'b1,16'h0000,4'd7},  // R7
    '{8'd0,  1'b1,2'd1,1'b0,16'h0000,1'b1,1'b1,16'h0422,4'd5},  // R5 miss
    '{8'd0,  1'b1,2'd1,1'b1,16'h0000,1'b0,1'b1,16'hF411,4'd12}, // R12
    '{8'd60, 1'b1,2'd1,1'b0,16'h0000,1'b0,1'b1,16'h0522,4'd5},  // R5 hit
    '{8'd0,  1'b1,2'd1,1'b1,16'h0000,1'b0,1'b1,16'hF511,4'd5},  // R5
    '{8'd0,  1'b1,2'd2,1'b0,16'h0000,1'b0,1'b1,16'h0018,4'd9},  // R9
    '{8'd0,  1'b0,2'd0,1'b0,16'h0001,1'b0,1'b0,16'h0000,4'd11}, // R11 prefetch
    '{8'd0,  1'b1,2'd0,1'b0,16'h0000,1'b0,1'b1,16'h0001,4'd11}, // R11 fill flag
    '{8'd0,  1'b0,2'd2,1'b0,16'h0040,1'b1,1'b0,16'h0000,4'd3},  // R3 after prefetch
    '{8'd0,  1'b0,2'd2,1'b1,16'h0000,1'b1,1'b0,16'h0000,4'd3},  // R3
    '{8'd4,  1'b0,2'd1,1'b0,16'h1111,1'b0,1'b0,16'h0000,4'd4},  // R4
    '{8'd0,  1'b0,2'd1,1'b1,16'hAAAA,1'b0,1'b0,16'h0000,4'd4},  // R4
    '{8'd0,  1'b0,2'd1,1'b0,16'h2222,1'b0,1'b0,16'h0000,4'd4},  // R4
    '{8'd0,  1'b0,2'd1,1'b1,16'hBBBB,1'b0,1'b0,16'h0000,4'd4},  // R4
    '{8'd0,  1'b0,2'd2,1'b0,16'h0080,1'b1,1'b0,16'h0000,4'd3},  // R3 FIFO not empty
    '{8'd0,  1'b0,2'd2,1'b1,16'h0000,1'b1,1'b0,16'h0000,4'd3},  // R3
    '{8'd4,  1'b1,2'd3,1'b0,16'h0000,1'b1,1'b1,16'h2022,4'd6},  // R6
    '{8'd0,  1'b1,2'd3,1'b1,16'h0000,1'b0,1'b1,16'hD011,4'd12}, // R12
    '{8'd0,  1'b0,2'd3,1'b0,16'h3333,1'b0,1'b0,16'h0000,4'd8},  // R8
    '{8'd0,  1'b0,2'd3,1'b1,16'hCCCC,1'b1,1'b0,16'h0000,4'd8},  // R8
    '{8'd0,  1'b1,2'd3,1'b0,16'h0000,1'b1,1'b1,16'h3333,4'd6},  // R6
    '{8'd0,  1'b1,2'd3,1'b1,16'h0000,1'b0,1'b1,16'hCCCC,4'd6},  // R6
    '{8'd0,  1'b1,2'd2,1'b0,16'h0000,1'b0,1'b1,16'h0080,4'd9},  // R9 fixed keeps addr
    '{8'd4,  1'b0,2'd2,1'b0,16'h0040,1'b0,1'b0,16'h0000,4'd3},  // R3
    '{8'd0,  1'b0,2'd2,1'b1,16'h0000,1'b1,1'b0,16'h0000,4'd3},  // R3
    '{8'd4,  1'b1,2'd3,1'b0,16'h0000,1'b1,1'b1,16'h1111,4'd10}, // R10 drained word
    '{8'd0,  1'b1,2'd3,1'b1,16'h0000,1'b0,1'b1,16'hAAAA,4'd10}, // R10
    '{8'd0,  1'b1,2'd0,1'b1,16'h0000,1'b0,1'b1,16'h0000,4'd7}   // R7
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic acc(input logic rd, input logic [1:0] sel, input logic half,
                     input logic [15:0] wd, output logic waited, output logic [15:0] q);
    @(negedge clk);
    host_sel_n = 0; host_rd = rd; reg_sel = sel; half_sel = half; hd_in = wd;
    strb_a_n = 0; strb_b_n = 1;
    #1 waited = host_ready_n;
    while (host_ready_n) begin @(negedge clk); #1; end
    q = hd_out;
    @(negedge clk); strb_a_n = 1;
  endtask

  logic w; logic [15:0] q;

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = {8'(i) ^ 8'hF0, 8'h11, 8'(i), 8'h22};
    repeat (3) @(negedge clk);
    #1 check(2, {31'b0, host_ready_n}, 0);  // R2 reset level
    check(10, {31'b0, mem_req}, 0);          // R10 idle memory port
    rst_n = 1;
    @(negedge clk);
    for (int k = 0; k < 32; k++) begin
      repeat (VT[k].gap) @(negedge clk);
      acc(VT[k].rd, VT[k].sel, VT[k].half, VT[k].wd, w, q);
      check(int'(VT[k].req), {31'b0, w}, {31'b0, VT[k].ew});
      if (VT[k].cd) check(int'(VT[k].req), {16'b0, q}, {16'b0, VT[k].ed});
    end

    // R1: both data strobes low, then chip-select high: no access
    repeat (4) @(negedge clk);
    host_rd = 0; reg_sel = 2'd2; half_sel = 0; hd_in = 16'hBEEF;
    strb_a_n = 0; strb_b_n = 0; repeat (3) @(negedge clk);
    host_sel_n = 1; strb_b_n = 1; repeat (3) @(negedge clk);
    strb_a_n = 1; host_sel_n = 0; repeat (4) @(negedge clk);
    acc(1, 2'd2, 0, 0, w, q); check(1, {16'b0, q}, 32'h0040); // R1

    // R4: fill write FIFO to 8 words, ninth word stalls for the full flush
    repeat (4) @(negedge clk);
    acc(0, 2'd2, 0, 16'h00C0, w, q);
    acc(0, 2'd2, 1, 16'h0000, w, q);
    repeat (4) @(negedge clk);
    for (int k = 0; k < 9; k++) begin
      acc(0, 2'd1, 0, 16'h7000 + 16'(k), w, q);
      check(4, {31'b0, w}, (k == 8) ? 1 : 0); // R4 full stall on ninth
      acc(0, 2'd1, 1, 16'h8000 + 16'(k), w, q);
      check(4, {31'b0, w}, 0);                 // R4
    end
    acc(0, 2'd2, 0, 16'h00C0, w, q); check(3, {31'b0, w}, 1); // R3 flush first
    acc(0, 2'd2, 1, 16'h0000, w, q);
    repeat (4) @(negedge clk);
    acc(1, 2'd3, 0, 0, w, q); check(10, {16'b0, q}, 32'h7000); // R10 order
    acc(1, 2'd3, 1, 0, w, q); check(10, {16'b0, q}, 32'h8000); // R10
    repeat (4) @(negedge clk);
    acc(0, 2'd2, 0, 16'h00E0, w, q);
    acc(0, 2'd2, 1, 16'h0000, w, q);
    repeat (4) @(negedge clk);
    acc(1, 2'd3, 0, 0, w, q); check(10, {16'b0, q}, 32'h7008); // R10 last word
    acc(1, 2'd3, 1, 0, w, q); check(10, {16'b0, q}, 32'h8008); // R10

    // R2: stalled address write, chip-select raised mid-stall
    acc(0, 2'd1, 0, 16'h5555, w, q);
    acc(0, 2'd1, 1, 16'h6666, w, q);   // addr -> 0xE4
    @(negedge clk);
    host_rd = 0; reg_sel = 2'd2; half_sel = 0; hd_in = 16'h0000;
    strb_a_n = 0; strb_b_n = 1;
    #1 check(2, {31'b0, host_ready_n}, 1); // R2 stalled while selected
    #1 host_sel_n = 1;
    #1 check(2, {31'b0, host_ready_n}, 0); // R2 deselect forces ready
    @(negedge clk); strb_a_n = 1;
    @(negedge clk); host_sel_n = 0;
    repeat (20) @(negedge clk);
    acc(1, 2'd2, 0, 0, w, q); check(9, {16'b0, q}, 32'h00E4); // R9 abort left addr

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule